// File: doc/BRIEF.md
# Memory-Mapped Interrupt Hub

The interrupt hub gathers a set of interrupt request lines (32 by default) into one request signal for a processor. Every request line is captured into a sticky status bit, and the status bits are filtered through a per-line enable mask to form the pending set. Software reads the pending set, or reads a vector word that names the lowest-numbered pending line. It then clears the captured bits by writing ones to an acknowledge word.

The enable mask can be written as a whole word. It can also be changed bit by bit through two write-only alias words, one that sets bits and one that clears them, so that no read-modify-write is needed. A two-bit master control word gates the outgoing request and selects where status bits come from. With hardware capture switched on, they come from the request lines. With it switched off, they come from software writes, which supports self-test. The register port is a plain single-cycle port addressed by word index.

Top module: `intr_hub`

## Requirements
- R1: While `rst_n` is low, and after it is released, status, enable and master control are all zero, `irq_out` is low and the vector word reads 0xFFFFFFFF.
- R2: While master bit 1 (hardware capture) is set, any rising clock edge at which `irq_in[n]` is high sets status bit n, and the bit stays set after the input falls until it is acknowledged.
- R3: A write to word index 3 (acknowledge) clears every status bit whose written bit is 1 and leaves the others unchanged. If a line is being captured at the same edge, its status bit stays set.
- R4: A write to word index 4 (set-enable) sets every enable bit whose written bit is 1 and leaves the others unchanged.
- R5: A write to word index 5 (clear-enable) clears every enable bit whose written bit is 1 and leaves the others unchanged.
- R6: A write to word index 2 (enable) replaces the whole enable mask, so writing zero disables every line. The request lines do not change the enable mask.
- R7: Word index 1 (pending) reads as status AND enable, and writes to it are ignored.
- R8: Word index 6 (vector) reads the number of the lowest-numbered pending line, or 0xFFFFFFFF when no line is pending. Writes to it are ignored.
- R9: `irq_out` is high exactly when master bit 0 is set and at least one line is pending. The output is combinational from the registers.
- R10: While master bit 1 is clear, `irq_in` has no effect on status, and a write to word index 0 (status) sets every status bit whose written bit is 1. While master bit 1 is set, writes to word index 0 are ignored.
- R11: Reads of word indices 3, 4 and 5 return zero. Word index 7 (master) stores written bits [1:0], and the remaining bits read as zero.
- R12: A register is written at the rising clock edge when `bus_sel` and `bus_wr` are both high, selected by `reg_word`. Read data is combinational in the same cycle when `bus_sel` is high and `bus_wr` is low, and it is zero otherwise. With `bus_sel` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| reg_word | input | 3 | Word index of the register (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq_in | input | NUM_LINES | Interrupt request lines |
| irq_out | output | 1 | Request to the processor |

## Verification
The assertions take for granted that the port is used by one agent: at most one word index is accessed per cycle, and the control inputs are known whenever reset is released. The sticky-status and acknowledge properties also rely on `irq_in` being sampled only at rising edges, with no further meaning given to glitches between edges. The bench changes every input at falling edges only and issues one access per cycle. It writes the status word only while hardware capture is off, except for the one write it makes on purpose to show that the word is ignored.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;

   localparam int unsigned SLOT_COUNT = 8;
   localparam int unsigned SLOT_W     = $clog2(SLOT_COUNT);
   localparam int unsigned MASTER_W   = 2;

   typedef enum logic [SLOT_W-1:0] {
      SLOT_STATUS = 3'd0,
      SLOT_PEND   = 3'd1,
      SLOT_ENABLE = 3'd2,
      SLOT_ACK    = 3'd3,
      SLOT_SETEN  = 3'd4,
      SLOT_CLREN  = 3'd5,
      SLOT_VECTOR = 3'd6,
      SLOT_MASTER = 3'd7
   } slot_e;

   typedef struct packed {
      logic status;
      logic enable;
      logic ack;
      logic set_en;
      logic clr_en;
      logic master;
   } wr_strobe_t;

endpackage

// File: rtl/intr_hub_port.sv
module intr_hub_port
   import intr_hub_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [SLOT_W-1:0]    reg_word,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [NUM_LINES-1:0] status_q,
   input  logic [NUM_LINES-1:0] enable_q,
   input  logic [NUM_LINES-1:0] pend,
   input  logic [DATA_W-1:0]    vec,
   output wr_strobe_t           stb,
   output logic [MASTER_W-1:0]  master_q,
   output logic [DATA_W-1:0]    bus_rdata
);

   slot_e slot;
   logic  wr_go;
   logic  rd_go;

   assign slot  = slot_e'(reg_word);
   assign wr_go = bus_sel & bus_wr;
   assign rd_go = bus_sel & ~bus_wr;

   // Write strobe decode: one register per access
   always_comb begin
      stb        = '0;
      stb.status = wr_go && (slot == SLOT_STATUS);
      stb.enable = wr_go && (slot == SLOT_ENABLE);
      stb.ack    = wr_go && (slot == SLOT_ACK);
      stb.set_en = wr_go && (slot == SLOT_SETEN);
      stb.clr_en = wr_go && (slot == SLOT_CLREN);
      stb.master = wr_go && (slot == SLOT_MASTER);
   end

   // Master control word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master_q <= '0;
      end else if (stb.master) begin
         master_q <= bus_wdata[MASTER_W-1:0];
      end
   end

   // Zero-extended views of narrower state
   logic [DATA_W-1:0] sts_w;
   logic [DATA_W-1:0] en_w;
   logic [DATA_W-1:0] pend_w;
   logic [DATA_W-1:0] mst_w;

   always_comb begin
      sts_w  = '0;
      en_w   = '0;
      pend_w = '0;
      mst_w  = '0;
      sts_w[NUM_LINES-1:0]  = status_q;
      en_w[NUM_LINES-1:0]   = enable_q;
      pend_w[NUM_LINES-1:0] = pend;
      mst_w[MASTER_W-1:0]   = master_q;
   end

   // Read multiplexer; aliases and idle cycles return zero
   always_comb begin
      bus_rdata = '0;
      if (rd_go) begin
         case (slot)
            SLOT_STATUS: bus_rdata = sts_w;
            SLOT_PEND:   bus_rdata = pend_w;
            SLOT_ENABLE: bus_rdata = en_w;
            SLOT_VECTOR: bus_rdata = vec;
            SLOT_MASTER: bus_rdata = mst_w;
            default:     bus_rdata = '0;
         endcase
      end
   end

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0)); // R12

   AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stb.master |=> $stable(master_q)); // R12

endmodule

// File: rtl/intr_hub_lines.sv
module intr_hub_lines
   import intr_hub_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 hw_en,
   input  logic [NUM_LINES-1:0] wdata,
   input  wr_strobe_t           stb,
   output logic [NUM_LINES-1:0] status_q,
   output logic [NUM_LINES-1:0] enable_q
);

   logic [NUM_LINES-1:0] gate_in;
   logic [NUM_LINES-1:0] ack_bits;
   logic [NUM_LINES-1:0] sw_bits;

   assign gate_in  = hw_en ? irq_in : '0;
   assign ack_bits = stb.ack ? wdata : '0;
   assign sw_bits  = (stb.status && !hw_en) ? wdata : '0;

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic sts_d;
      logic en_d;

      // Capture wins over a same-edge acknowledge
      assign sts_d = (status_q[n] & ~ack_bits[n]) | gate_in[n] | sw_bits[n];

      always_comb begin
         en_d = enable_q[n];
         if (stb.enable) begin
            en_d = wdata[n];
         end else if (stb.set_en && wdata[n]) begin
            en_d = 1'b1;
         end else if (stb.clr_en && wdata[n]) begin
            en_d = 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            status_q[n] <= 1'b0;
            enable_q[n] <= 1'b0;
         end else begin
            status_q[n] <= sts_d;
            enable_q[n] <= en_d;
         end
      end
   end

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(status_q) & ~status_q) & ~$past(ack_bits)) == '0)); // R2

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stb.ack |=> ((status_q & $past(wdata) & ~$past(gate_in)) == '0)); // R3

   AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_en && !stb.status) |=> ((status_q & ~$past(status_q)) == '0)); // R10

   AST_SET_EN: assert property (@(posedge clk) disable iff (!rst_n)
      stb.set_en |=> ((enable_q & $past(wdata)) == $past(wdata))); // R4

   AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
      stb.clr_en |=> ((enable_q & $past(wdata)) == '0)); // R5

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(stb.enable || stb.set_en || stb.clr_en) |=> $stable(enable_q)); // R6

endmodule

// File: rtl/intr_hub_pick.sv
module intr_hub_pick #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          USE_TREE  = 1'b1
) (
   input  logic [NUM_LINES-1:0] pend,
   output logic [DATA_W-1:0]    vec
);

   localparam int unsigned IDX_W = $clog2(NUM_LINES);
   localparam int unsigned SPAN  = 1 << IDX_W;

   logic             found;
   logic [IDX_W-1:0] idx;

   if (USE_TREE) begin : g_tree
      // Pairwise reduction, left (lower index) child preferred
      logic [IDX_W:0][SPAN-1:0]            vv;
      logic [IDX_W:0][SPAN-1:0][IDX_W-1:0] ii;

      always_comb begin
         vv = '0;
         ii = '0;
         vv[0][NUM_LINES-1:0] = pend;
         for (int k = 0; k < SPAN; k++) begin
            ii[0][k] = IDX_W'(k);
         end
         for (int l = 1; l <= IDX_W; l++) begin
            for (int k = 0; k < SPAN / 2; k++) begin
               if (k < (SPAN >> l)) begin
                  vv[l][k] = vv[l-1][2*k] | vv[l-1][2*k+1];
                  ii[l][k] = vv[l-1][2*k] ? ii[l-1][2*k] : ii[l-1][2*k+1];
               end
            end
         end
      end

      assign found = vv[IDX_W][0];
      assign idx   = ii[IDX_W][0];
   end else begin : g_scan
      // Downward scan, last hit is the lowest index
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (pend[i]) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
   end

   assign vec = found ? DATA_W'(idx) : '1;

endmodule

// File: rtl/intr_hub.sv
module intr_hub
   import intr_hub_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_LINES = 32,
   parameter bit          USE_TREE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [2:0]           reg_word,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic                 irq_out
);

   localparam int unsigned IDX_W = $clog2(NUM_LINES);

   if (NUM_LINES < 2 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("intr_hub: NUM_LINES must lie in 2..DATA_W");
   end
   if (DATA_W < MASTER_W) begin : g_bad_width
      $error("intr_hub: DATA_W too narrow for master control");
   end
   if (SLOT_W != 3) begin : g_bad_slots
      $error("intr_hub: register index width must be 3");
   end

   wr_strobe_t            stb;
   logic [MASTER_W-1:0]   master_q;
   logic [NUM_LINES-1:0]  status_q;
   logic [NUM_LINES-1:0]  enable_q;
   logic [NUM_LINES-1:0]  pend;
   logic [DATA_W-1:0]     vec;

   intr_hub_port #(
      .DATA_W    (DATA_W),
      .NUM_LINES (NUM_LINES)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .reg_word  (reg_word),
      .bus_wdata (bus_wdata),
      .status_q  (status_q),
      .enable_q  (enable_q),
      .pend      (pend),
      .vec       (vec),
      .stb       (stb),
      .master_q  (master_q),
      .bus_rdata (bus_rdata)
   );

   intr_hub_lines #(
      .NUM_LINES (NUM_LINES)
   ) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .hw_en    (master_q[1]),
      .wdata    (bus_wdata[NUM_LINES-1:0]),
      .stb      (stb),
      .status_q (status_q),
      .enable_q (enable_q)
   );

   assign pend = status_q & enable_q;

   intr_hub_pick #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W),
      .USE_TREE  (USE_TREE)
   ) u_pick (
      .pend (pend),
      .vec  (vec)
   );

   assign irq_out = master_q[0] & (|pend);

   // Checker helpers
   logic [IDX_W-1:0]     vec_idx;
   logic [NUM_LINES-1:0] below_mask;
   assign vec_idx    = vec[IDX_W-1:0];
   assign below_mask = (NUM_LINES'(1) << vec_idx) - NUM_LINES'(1);

   AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (vec != '1) |-> (pend[vec_idx] && ((pend & below_mask) == '0))); // R8

   AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend != '0) |-> (vec != '1)); // R8

   AST_IRQ_HAS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (vec != '1)); // R9

endmodule

// File: tb/intr_hub_test.sv
`timescale 1ns/1ps
module intr_hub_test;

   localparam logic [2:0] W_STS = 3'd0;
   localparam logic [2:0] W_PND = 3'd1;
   localparam logic [2:0] W_EN  = 3'd2;
   localparam logic [2:0] W_ACK = 3'd3;
   localparam logic [2:0] W_SIE = 3'd4;
   localparam logic [2:0] W_CIE = 3'd5;
   localparam logic [2:0] W_VEC = 3'd6;
   localparam logic [2:0] W_MST = 3'd7;
   localparam logic       WR = 1'b1;
   localparam logic       RD = 1'b0;

   // {wr, word, data/expected, irq_in, expected irq_out, requirement}
   localparam int NV = 50;
   localparam logic [72:0] TBL [NV] = '{
      {RD, W_MST, 32'h0000_0000, 32'h0, 1'b0, 4'd1},   // R1
      {RD, W_VEC, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd1},   // R1
      {RD, W_STS, 32'h0000_0000, 32'h0, 1'b0, 4'd1},   // R1
      {WR, W_STS, 32'h0000_0005, 32'h0, 1'b0, 4'd10},  // R10
      {RD, W_STS, 32'h0000_0005, 32'h0, 1'b0, 4'd10},  // R10
      {RD, W_PND, 32'h0000_0000, 32'h0, 1'b0, 4'd7},   // R7
      {WR, W_SIE, 32'h0000_0004, 32'h0, 1'b0, 4'd4},   // R4
      {RD, W_EN,  32'h0000_0004, 32'h0, 1'b0, 4'd4},   // R4
      {RD, W_PND, 32'h0000_0004, 32'h0, 1'b0, 4'd7},   // R7
      {RD, W_VEC, 32'h0000_0002, 32'h0, 1'b0, 4'd8},   // R8
      {WR, W_SIE, 32'h0000_0011, 32'h0, 1'b0, 4'd4},   // R4
      {RD, W_EN,  32'h0000_0015, 32'h0, 1'b0, 4'd4},   // R4
      {RD, W_PND, 32'h0000_0005, 32'h0, 1'b0, 4'd7},   // R7
      {RD, W_VEC, 32'h0000_0000, 32'h0, 1'b0, 4'd8},   // R8
      {WR, W_CIE, 32'h0000_0001, 32'h0, 1'b0, 4'd5},   // R5
      {RD, W_EN,  32'h0000_0014, 32'h0, 1'b0, 4'd5},   // R5
      {RD, W_VEC, 32'h0000_0002, 32'h0, 1'b0, 4'd8},   // R8
      {RD, W_SIE, 32'h0000_0000, 32'h0, 1'b0, 4'd11},  // R11
      {RD, W_CIE, 32'h0000_0000, 32'h0, 1'b0, 4'd11},  // R11
      {RD, W_ACK, 32'h0000_0000, 32'h0, 1'b0, 4'd11},  // R11
      {WR, W_ACK, 32'h0000_0004, 32'h0, 1'b0, 4'd3},   // R3
      {RD, W_STS, 32'h0000_0001, 32'h0, 1'b0, 4'd3},   // R3
      {RD, W_VEC, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd8},   // R8
      {WR, W_EN,  32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 4'd6},  // R6
      {RD, W_EN,  32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 4'd6},  // R6
      {RD, W_STS, 32'h0000_0001, 32'h8000_0000, 1'b0, 4'd10}, // R10
      {WR, W_MST, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd11},  // R11
      {RD, W_MST, 32'h0000_0003, 32'h0, 1'b1, 4'd11},  // R11
      {RD, W_PND, 32'h0000_0001, 32'h0, 1'b1, 4'd9},   // R9
      {WR, W_STS, 32'h0000_0002, 32'h0, 1'b0, 4'd10},  // R10
      {RD, W_STS, 32'h0000_0001, 32'h0, 1'b1, 4'd10},  // R10
      {WR, W_ACK, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd3},   // R3
      {RD, W_STS, 32'h0000_0000, 32'h0, 1'b0, 4'd3},   // R3
      {WR, W_EN,  32'h8000_0000, 32'h8000_0000, 1'b0, 4'd2},  // R2
      {RD, W_STS, 32'h8000_0000, 32'h0, 1'b1, 4'd2},   // R2
      {RD, W_VEC, 32'h0000_001F, 32'h0, 1'b1, 4'd8},   // R8
      {WR, W_ACK, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'd3},  // R3
      {RD, W_STS, 32'h8000_0000, 32'h0, 1'b1, 4'd3},   // R3
      {WR, W_ACK, 32'h8000_0000, 32'h0, 1'b0, 4'd3},   // R3
      {RD, W_STS, 32'h0000_0000, 32'h0, 1'b0, 4'd3},   // R3
      {WR, W_MST, 32'h0000_0002, 32'h0000_0100, 1'b0, 4'd2},  // R2
      {WR, W_EN,  32'h0000_0100, 32'h0, 1'b0, 4'd6},   // R6
      {RD, W_PND, 32'h0000_0100, 32'h0, 1'b0, 4'd9},   // R9
      {RD, W_VEC, 32'h0000_0008, 32'h0, 1'b0, 4'd8},   // R8
      {WR, W_MST, 32'h0000_0003, 32'h0, 1'b0, 4'd9},   // R9
      {RD, W_PND, 32'h0000_0100, 32'h0, 1'b1, 4'd9},   // R9
      {WR, W_EN,  32'h0000_0000, 32'h0, 1'b0, 4'd6},   // R6
      {RD, W_PND, 32'h0000_0000, 32'h0, 1'b0, 4'd7},   // R7
      {RD, W_STS, 32'h0000_0100, 32'h0, 1'b0, 4'd7},   // R7
      {RD, W_VEC, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd8}    // R8
   };

   logic        clk;
   logic        rst_n;
   logic        bus_sel;
   logic        bus_wr;
   logic [2:0]  reg_word;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [31:0] irq_in;
   logic        irq_out;

   int n_run;
   int n_fail;

   intr_hub uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .reg_word  (reg_word),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_in    (irq_in),
      .irq_out   (irq_out)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic put(input logic wr, input logic [2:0] w, input logic [31:0] d);
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = wr;
      reg_word  = w;
      bus_wdata = d;
   endtask

   task automatic rd_check(input string tag, input logic [2:0] w, input logic [31:0] exp,
                           input logic exp_irq);
      put(RD, w, 32'h0);
      #1;
      check(tag, bus_rdata, exp);
      check({tag, " irq_out"}, {31'b0, irq_out}, {31'b0, exp_irq});
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sel = 1'b0;
      bus_wr  = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      n_run     = 0;
      n_fail    = 0;
      rst_n     = 1'b0;
      bus_sel   = 1'b0;
      bus_wr    = 1'b0;
      reg_word  = '0;
      bus_wdata = '0;
      irq_in    = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);

      // Table walk
      for (int s = 0; s < NV; s++) begin
         logic [72:0] e;
         e = TBL[s];
         @(negedge clk);
         irq_in    = e[36:5];
         bus_sel   = 1'b1;
         bus_wr    = e[72];
         reg_word  = e[71:69];
         bus_wdata = e[72] ? e[68:37] : 32'h0;
         if (!e[72]) begin
            #1;
            n_run++;
            if (bus_rdata !== e[68:37]) begin
               n_fail++;
               $display("FAIL R%0d step %0d rdata actual=%08h expected=%08h",
                        e[3:0], s, bus_rdata, e[68:37]);
            end
            n_run++;
            if (irq_out !== e[4]) begin
               n_fail++;
               $display("FAIL R%0d step %0d irq_out actual=%0b expected=%0b",
                        e[3:0], s, irq_out, e[4]);
            end
         end
      end
      idle();
      irq_in = '0;

      // R12: write with bus_sel low does nothing, idle read is zero
      @(negedge clk);
      bus_sel   = 1'b0;
      bus_wr    = 1'b1;
      reg_word  = W_EN;
      bus_wdata = 32'hFFFF_FFFF;
      #1;
      check("R12 idle rdata", bus_rdata, 32'h0);
      idle();
      rd_check("R12 enable unchanged", W_EN, 32'h0, 1'b0);

      // R12: write of read-only vector word ignored
      put(WR, W_VEC, 32'h0000_0000);
      rd_check("R12 vector write ignored", W_VEC, 32'hFFFF_FFFF, 1'b0);

      // R1: reset in mid-operation
      put(WR, W_SIE, 32'h0000_0F00);
      rd_check("R9 pending before reset", W_PND, 32'h0000_0100, 1'b1);
      idle();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd_check("R1 status cleared", W_STS, 32'h0, 1'b0);
      rd_check("R1 enable cleared", W_EN, 32'h0, 1'b0);
      rd_check("R1 master cleared", W_MST, 32'h0, 1'b0);
      rd_check("R1 vector none", W_VEC, 32'hFFFF_FFFF, 1'b0);
      idle();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule